// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This unit performs decimal arithmetic on one packed byte at a time: the upper nibble holds the tens digit and the lower nibble the units digit. It can add two such bytes, subtract one from another, or negate a byte, subtracting it from zero. An incoming extend flag serves as the carry in for addition and as the borrow in for subtraction and negation. The unit returns the decimal result together with new carry, extend and zero flags.

Numbers longer than one byte are processed one byte per cycle, starting with the least significant byte. The caller feeds the extend output back as the next extend input and the zero output back as the next zero input. The zero flag is sticky: it drops on any nonzero byte and is otherwise passed through unchanged. It should start at 1, so that at the end of the chain it reports whether the whole multi-byte value is zero. Results are registered and are marked by a one-cycle done pulse.

Top module: `bcd_byte_unit`

## Requirements
- R1: While reset is asserted, and until a valid operation is accepted after reset, the result is 0x00, the carry, extend and zero flags are 0, and done is 0.
- R2: With start high and operation code 2'b00, the next result is (dst + src + x_in) mod 100 in decimal, tens digit in bits 7:4 and units digit in bits 3:0. Carry is 1 exactly when the decimal sum exceeds 99.
- R3: With start high and operation code 2'b01, the next result is (dst - src - x_in) mod 100 in decimal. Carry is 1 exactly when the decimal difference is negative.
- R4: With start high and operation code 2'b10, the next result is (0 - dst - x_in) mod 100 in decimal, and src is ignored. Carry is 1 exactly when dst or x_in is nonzero.
- R5: After each accepted operation, the extend output equals the carry output.
- R6: After each accepted operation, the zero flag is 0 if the result is nonzero. If the result is zero, the zero flag equals z_in as sampled with the operation.
- R7: The outputs of an accepted operation appear on the first rising clock edge after start is sampled. Done is high for exactly that cycle.
- R8: When start is low, or the operation code is the reserved value 2'b11, done stays 0 and the result and all flags keep their values.
- R9: Chaining bytes from least to most significant, with x_out and z_out fed back as x_in and z_in, produces the correct multi-byte decimal sum or difference, the final carry or borrow, and a zero flag for the whole value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request an operation this cycle |
| op_i | input | 2 | 00 add, 01 subtract, 10 negate, 11 reserved |
| dst_i | input | 8 | Destination operand, two packed decimal digits |
| src_i | input | 8 | Source operand, two packed decimal digits |
| x_in | input | 1 | Incoming extend flag, used as carry or borrow in |
| z_in | input | 1 | Incoming zero flag |
| res_o | output | 8 | Registered decimal result |
| c_o | output | 1 | Carry or borrow out |
| x_o | output | 1 | Extend out |
| z_o | output | 1 | Sticky zero flag out |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
Every result, flag and the done pulse are due one rising edge after the cycle in which start is sampled. The bench drives inputs on the falling edge and compares all outputs on the next falling edge, so each comparison lands exactly one register stage after its stimulus. The reference model advances only when an operation is accepted and otherwise holds its last values. The same comparison therefore also checks that idle cycles and the reserved code leave the outputs untouched. Addition and subtraction are swept over every valid digit pair with both extend values, and negation over every valid byte; multi-byte chains then test carry propagation across bytes and the sticky zero flag.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_NEG = 2'b10,
    OP_RSV = 2'b11
  } bcd_op_e;
endpackage

// File: rtl/bcd_digit_cell.sv
// One decimal digit: binary add or subtract with carry/borrow, then a +6/-6 fix.
module bcd_digit_cell (
  input  logic       sub_i,
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cy_i,
  output logic [3:0] d_o,
  output logic       cy_o
);
  logic [4:0] raw;
  logic       fix;

  always_comb begin
    if (sub_i) begin
      raw = {1'b0, a_i} - {1'b0, b_i} - {4'b0, cy_i};
      fix = raw[4];
      d_o = raw[3:0] - (fix ? 4'd6 : 4'd0);
    end else begin
      raw = {1'b0, a_i} + {1'b0, b_i} + {4'b0, cy_i};
      fix = (raw > 5'd9);
      d_o = raw[3:0] + (fix ? 4'd6 : 4'd0);
    end
    cy_o = fix;
  end

  // R2 R3: for valid digits the corrected digit is again a valid digit
  always_comb begin
    if (a_i <= 4'd9 && b_i <= 4'd9) begin
      p_digit_range_r2: assert (d_o <= 4'd9);
    end
  end
endmodule

// File: rtl/bcd_operand_sel.sv
// Maps the operation code onto a minuend/addend, an operand and a direction.
module bcd_operand_sel #(
  parameter int W = 8
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         sub_o,
  output logic         valid_o
);
  import bcd_pkg::*;

  always_comb begin
    a_o     = dst_i;
    b_o     = src_i;
    sub_o   = 1'b0;
    valid_o = 1'b1;
    case (op_i)
      OP_ADD: sub_o = 1'b0;
      OP_SUB: sub_o = 1'b1;
      OP_NEG: begin
        a_o   = '0;
        b_o   = dst_i;
        sub_o = 1'b1;
      end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcd_chain.sv
// Ripple of decimal digit cells, least significant digit first.
module bcd_chain #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  output logic [W-1:0] d_o,
  output logic         cy_o
);
  logic [DIGITS:0] cy;

  assign cy[0] = cy_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    bcd_digit_cell u_cell (
      .sub_i (sub_i),
      .a_i   (a_i[4*g +: 4]),
      .b_i   (b_i[4*g +: 4]),
      .cy_i  (cy[g]),
      .d_o   (d_o[4*g +: 4]),
      .cy_o  (cy[g+1])
    );
  end

  assign cy_o = cy[DIGITS];
endmodule

// File: rtl/bcd_byte_unit.sv
module bcd_byte_unit #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  input  logic         x_in,
  input  logic         z_in,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         x_o,
  output logic         z_o,
  output logic         done_o
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync;
  logic       rs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rs = rst_sync[1];

  // Datapath
  logic [W-1:0] a_w, b_w, sum_w;
  logic         sub_w, valid_w, cy_w;

  bcd_operand_sel #(.W(W)) u_sel (
    .op_i    (op_i),
    .dst_i   (dst_i),
    .src_i   (src_i),
    .a_o     (a_w),
    .b_o     (b_w),
    .sub_o   (sub_w),
    .valid_o (valid_w)
  );

  bcd_chain #(.DIGITS(DIGITS)) u_chain (
    .sub_i (sub_w),
    .a_i   (a_w),
    .b_i   (b_w),
    .cy_i  (x_in),
    .d_o   (sum_w),
    .cy_o  (cy_w)
  );

  // Next-state
  logic         go;
  logic [W-1:0] res_d;
  logic         c_d, z_d;

  always_comb begin
    go    = start_i & valid_w;
    res_d = sum_w;
    c_d   = cy_w;
    z_d   = (sum_w != '0) ? 1'b0 : z_in;
  end

  // Registers
  logic [W-1:0] res_q;
  logic         c_q, x_q, z_q, done_q;

  always_ff @(posedge clk or negedge rs) begin
    if (!rs) begin
      res_q  <= '0;
      c_q    <= 1'b0;
      x_q    <= 1'b0;
      z_q    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= go;
      if (go) begin
        res_q <= res_d;
        c_q   <= c_d;
        x_q   <= c_d;
        z_q   <= z_d;
      end
    end
  end

  assign res_o  = res_q;
  assign c_o    = c_q;
  assign x_o    = x_q;
  assign z_o    = z_q;
  assign done_o = done_q;

  // Assertions
  p_done_follows_r7: assert property (@(posedge clk) disable iff (!rs)
    $past(rs) |-> (done_o == $past(start_i && op_i != 2'b11)));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rs)
    ($past(rs) && !$past(go)) |-> ($stable(res_o) && $stable(c_o) && $stable(x_o) && $stable(z_o)));

  p_x_eq_c_r5: assert property (@(posedge clk) disable iff (!rs)
    done_o |-> (x_o == c_o));

  p_z_clear_r6: assert property (@(posedge clk) disable iff (!rs)
    (done_o && res_o != '0) |-> !z_o);

  p_z_keep_r6: assert property (@(posedge clk) disable iff (!rs)
    ($past(rs) && done_o && res_o == '0) |-> (z_o == $past(z_in)));
endmodule

// File: tb/sim_bcd_byte_unit.sv
`timescale 1ns/1ps
module sim_bcd_byte_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [1:0] op_i;
  logic [7:0] dst_i, src_i;
  logic       x_in, z_in;
  logic [7:0] res_o;
  logic       c_o, x_o, z_o, done_o;

  int  ntest = 0;
  int  nfail = 0;
  bit  finished = 1'b0;

  logic [7:0] e_res;
  logic       e_c, e_x, e_z, e_done;

  always #2.5 clk = ~clk;

  bcd_byte_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .dst_i(dst_i), .src_i(src_i), .x_in(x_in), .z_in(z_in),
    .res_o(res_o), .c_o(c_o), .x_o(x_o), .z_o(z_o), .done_o(done_o)
  );

  function automatic int to_int(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic compare(input string tag);
    ntest++;
    if (res_o !== e_res || c_o !== e_c || x_o !== e_x || z_o !== e_z || done_o !== e_done) begin
      nfail++;
      $display("FAIL %s: got res=%h c=%b x=%b z=%b done=%b, expected res=%h c=%b x=%b z=%b done=%b",
               tag, res_o, c_o, x_o, z_o, done_o, e_res, e_c, e_x, e_z, e_done);
    end
  endtask

  // Drive at a falling edge, update the model, check at the next falling edge.
  task automatic cyc(input logic st, input logic [1:0] op, input logic [7:0] d,
                     input logic [7:0] s, input logic x, input logic z, input string tag);
    int t;
    start_i = st; op_i = op; dst_i = d; src_i = s; x_in = x; z_in = z;
    e_done = st && (op != 2'b11);
    if (e_done) begin
      case (op)
        2'b00:   t = to_int(d) + to_int(s) + int'(x);
        2'b01:   t = to_int(d) - to_int(s) - int'(x);
        default: t = 0 - to_int(d) - int'(x);
      endcase
      e_c   = (op == 2'b00) ? (t > 99) : (t < 0);
      e_x   = e_c;
      e_res = to_bcd((t + 100) % 100);
      e_z   = (e_res != 8'h00) ? 1'b0 : z;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  // Multi-byte chain, least significant byte first (R9)
  task automatic chain(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] want, input logic want_c, input logic want_z);
    logic [31:0] got;
    logic        xx, zz;
    xx = 1'b0; zz = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, op, a[8*i +: 8], b[8*i +: 8], xx, zz, "R9 chain byte");
      got[8*i +: 8] = res_o;
      xx = x_o; zz = z_o;
    end
    ntest++;
    if (got !== want || xx !== want_c || zz !== want_z) begin
      nfail++;
      $display("FAIL R9: got %h c=%b z=%b, expected %h c=%b z=%b", got, xx, zz, want, want_c, want_z);
    end
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b1; op_i = 2'b00; dst_i = 8'h45; src_i = 8'h67;
    x_in = 1'b1; z_in = 1'b1;
    e_res = 8'h00; e_c = 1'b0; e_x = 1'b0; e_z = 1'b0; e_done = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    start_i = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 after release");

    // R2 addition, all digit pairs, both extend values
    for (int d = 0; d < 100; d++)
      for (int s = 0; s < 100; s++)
        for (int x = 0; x < 2; x++)
          cyc(1'b1, 2'b00, to_bcd(d), to_bcd(s), x[0], s[0], "R2/R5/R6/R7 add");

    // R8 idle and reserved code leave outputs unchanged
    cyc(1'b0, 2'b00, 8'h12, 8'h34, 1'b0, 1'b1, "R8 start low");
    cyc(1'b1, 2'b11, 8'h99, 8'h99, 1'b1, 1'b0, "R8 reserved op");

    // R3 subtraction, all digit pairs, both borrow values
    for (int d = 0; d < 100; d++)
      for (int s = 0; s < 100; s++)
        for (int x = 0; x < 2; x++)
          cyc(1'b1, 2'b01, to_bcd(d), to_bcd(s), x[0], d[0], "R3/R5/R6/R7 sub");

    cyc(1'b1, 2'b11, 8'h00, 8'h00, 1'b0, 1'b1, "R8 reserved op after sub");

    // R4 negation, src must not matter
    for (int d = 0; d < 100; d++)
      for (int x = 0; x < 2; x++)
        cyc(1'b1, 2'b10, to_bcd(d), to_bcd(99 - d), x[0], 1'b1, "R4/R5/R6 neg");

    // R6 zero result with z_in low keeps zero flag low
    cyc(1'b1, 2'b00, 8'h00, 8'h00, 1'b0, 1'b0, "R6 zero keeps z_in=0");
    cyc(1'b1, 2'b10, 8'h00, 8'h55, 1'b0, 1'b1, "R6 zero keeps z_in=1");
    cyc(1'b0, 2'b01, 8'h77, 8'h11, 1'b1, 1'b0, "R8 hold after zero");

    chain(2'b00, 32'h12345678, 32'h87654321, 32'h99999999, 1'b0, 1'b0);
    chain(2'b00, 32'h99999999, 32'h00000001, 32'h00000000, 1'b1, 1'b1);
    chain(2'b01, 32'h00000000, 32'h00000001, 32'h99999999, 1'b1, 1'b0);
    chain(2'b01, 32'h50000000, 32'h50000000, 32'h00000000, 1'b0, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      ntest++;
      nfail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end
endmodule